// File: doc/BRIEF.md
# Byte Memory Access Unit

This unit fronts a small byte-addressed store in which every byte is kept as nine bits: eight data bits plus an odd-parity bit. A requester asks for a transfer of one, two or four bytes. Each request carries a 24-bit start address, a size code, a 4-bit requester key and, for a store, right-justified store data. Bytes are laid out big-endian: the lowest address holds the most significant byte of the transfer. The store is divided into 2048-byte blocks, and each block has its own 4-bit protection key, loaded over a plain control port.

A read lands right-justified in a 32-bit destination word that the unit holds. A byte read replaces bits 7:0 and a halfword read replaces bits 15:0. In both cases the untouched upper bits keep their old value. Every request gets one response carrying four separate flags: addressing, specification, protection and machine check. When any flag is raised, the store is left as it was and the destination word does not change.

Requests and responses use valid/ready handshakes. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The response appears in the following cycle. `req_ready` stays low while a response is waiting, so only one request is outstanding at a time. While `rsp_ready` is low, the response and all of its fields stay unchanged. The key-load port and the destination output are plain signals.

Top module: `byte_access_unit`

## Requirements
- R1: A request accepted on an edge produces `rsp_valid` in the next cycle. `req_ready` is low whenever `rsp_valid` is high. While `rsp_ready` is low, the response and its fields stay unchanged.
- R2: Size code 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes. A specification exception is raised for code 3, for a 2-byte access at an odd address, and for a 4-byte access whose address bits 1:0 are not zero.
- R3: An addressing exception is raised when the last byte of the access (address + bytes − 1) is at or beyond the installed size, `MEM_BYTES` (default 4096).
- R4: A store writes the most significant byte of its right-justified data to the start address and the following bytes to the following addresses. Reads assemble bytes in the same order.
- R5: A successful read of N bytes replaces the low 8·N bits of the destination and keeps the upper bits. The response data equals the new destination value.
- R6: A store raises a protection exception when the requester key is nonzero and differs from the key of the addressed 2048-byte block. A requester key of 0 always passes. Reads never raise a protection exception.
- R7: Block keys reset to 0. A key load (`key_we`) takes effect for requests accepted after the load edge.
- R8: Stored bytes get odd parity. When `req_bad_par` is high, the parity bit is inverted instead. A read that returns any byte with even parity raises a machine check.
- R9: When any exception is raised, no stored byte changes, the destination is left unchanged, and the response data equals the unchanged destination. Store responses also return the destination unchanged.
- R10: After reset, `rsp_valid` is 0, `req_ready` is 1 and the destination is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = store, 0 = read |
| req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = invalid |
| req_addr | input | 24 | Start byte address |
| req_key | input | 4 | Requester protection key |
| req_wdata | input | 32 | Right-justified store data |
| req_bad_par | input | 1 | Store with inverted parity |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_data | output | 32 | Destination value after this request |
| rsp_addr_exc | output | 1 | Addressing exception |
| rsp_spec_exc | output | 1 | Specification exception |
| rsp_prot_exc | output | 1 | Protection exception |
| rsp_mchk | output | 1 | Parity error on read |
| dest_o | output | 32 | Current destination word |
| key_we | input | 1 | Load a block key |
| key_blk | input | 1 | Block index for the key load |
| key_val | input | 4 | Key value to load |

## Verification
The assertions check the following on every cycle:
- the response follows each accepted request and holds steady under back-pressure;
- a zero requester key never draws a protection flag, and reads never do;
- the destination does not move when a response carries an exception;
- a halfword read leaves the upper half of the destination alone;
- a machine check never arrives with an addressing or specification flag;
- a key load is visible in the key table one cycle later.

Byte ordering, suppression of the store on every exception kind, and the parity corruption path need the bench's scenarios. The same holds for the block-key boundaries and the exact addressing limit. The bench compares its model of storage contents and destination against the unit over long stretches of traffic to show these.

// File: rtl/mau_pkg.sv
package mau_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } size_e;

  typedef struct packed {
    logic addr;
    logic spec;
    logic prot;
  } exc_t;

  // odd parity: data plus parity bit hold an odd count of ones
  function automatic logic odd_par(input logic [7:0] d);
    return ~^d;
  endfunction

  function automatic logic [2:0] size_bytes(input size_e s);
    case (s)
      SZ_HALF: return 3'd2;
      SZ_WORD: return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/mau_key_table.sv
module mau_key_table #(
  parameter int NBLK  = 2,
  parameter int KEY_W = 4,
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [KEY_W-1:0] wkey,
  input  logic [IDX_W-1:0] ridx,
  output logic [KEY_W-1:0] rkey
);

  logic [KEY_W-1:0] keys [NBLK];

  for (genvar b = 0; b < NBLK; b++) begin : g_key
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        keys[b] <= '0;
      end else if (we && (int'(widx) == b)) begin
        keys[b] <= wkey;
      end
    end
  end

  always_comb begin
    rkey = '0;
    for (int b = 0; b < NBLK; b++) begin
      if (int'(ridx) == b) rkey = keys[b];
    end
  end

  AST_KEY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(widx) < NBLK) |=> keys[$past(widx)] == $past(wkey)) else $error("key load lost"); // R7

endmodule

// File: rtl/mau_req_check.sv
module mau_req_check
  import mau_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MEM_BYTES = 4096,
  parameter int KEY_W     = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              write,
  input  logic [KEY_W-1:0]  key,
  input  logic [KEY_W-1:0]  blk_key,
  output exc_t              exc,
  output logic [2:0]        nbytes
);

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_BYTES);

  size_e           sz;
  logic [ADDR_W:0] last;

  always_comb begin
    sz       = size_e'(size);
    nbytes   = size_bytes(sz);
    last     = {1'b0, addr} + (ADDR_W+1)'(nbytes) - (ADDR_W+1)'(1);
    exc.addr = (last >= LIMIT);
    exc.spec = (sz == SZ_BAD) ||
               ((sz == SZ_HALF) && addr[0]) ||
               ((sz == SZ_WORD) && (addr[1:0] != 2'b00));
    exc.prot = write && !exc.addr && (key != '0) && (key != blk_key);
  end

endmodule

// File: rtl/mau_lane_ram.sv
module mau_lane_ram #(
  parameter int ROWS  = 1024,
  parameter int ROW_W = 10,
  parameter int W     = 9
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [ROW_W-1:0] addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata
);

  logic [W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end

endmodule

// File: rtl/byte_access_unit.sv
module byte_access_unit
  import mau_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MEM_BYTES = 4096,
  parameter int BLK_BYTES = 2048,
  parameter int KEY_W     = 4,
  parameter int DATA_W    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [1:0]            req_size,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [KEY_W-1:0]      req_key,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic                  req_bad_par,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DATA_W-1:0]     rsp_data,
  output logic                  rsp_addr_exc,
  output logic                  rsp_spec_exc,
  output logic                  rsp_prot_exc,
  output logic                  rsp_mchk,
  output logic [DATA_W-1:0]     dest_o,
  input  logic                  key_we,
  input  logic [((MEM_BYTES/BLK_BYTES) > 1 ? $clog2(MEM_BYTES/BLK_BYTES) : 1)-1:0] key_blk,
  input  logic [KEY_W-1:0]      key_val
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int ROWS   = MEM_BYTES / LANES;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int NBLK   = MEM_BYTES / BLK_BYTES;
  localparam int IDX_W  = (NBLK > 1) ? $clog2(NBLK) : 1;
  localparam int BLK_SH = $clog2(BLK_BYTES);

  // request side
  logic             accept;
  exc_t             exc;
  logic             exc_any;
  logic [2:0]       nbytes;
  logic [KEY_W-1:0] blk_key;
  logic [IDX_W-1:0] blk_idx;
  logic [LANES-1:0] sel_vec;
  logic [8:0]       lane_rd [LANES];

  // response side
  logic              rsp_vq;
  exc_t              exc_q;
  logic              exc_any_q;
  logic              write_q;
  logic [2:0]        nbytes_q;
  logic [LANE_W-1:0] addr_lo_q;
  logic [LANES-1:0]  sel_q;
  logic [DATA_W-1:0] dest_q;
  logic [DATA_W-1:0] merged;
  logic [LANES-1:0]  par_bad;
  logic              mchk;
  logic [LANE_W-1:0] src_ln;

  assign req_ready = !rsp_vq;
  assign accept    = req_valid && req_ready;
  assign blk_idx   = req_addr[BLK_SH +: IDX_W];
  assign exc_any   = exc.addr | exc.spec | exc.prot;

  mau_key_table #(.NBLK(NBLK), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_keys (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (key_we),
    .widx (key_blk),
    .wkey (key_val),
    .ridx (blk_idx),
    .rkey (blk_key)
  );

  mau_req_check #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .KEY_W(KEY_W)) u_check (
    .addr   (req_addr),
    .size   (req_size),
    .write  (req_write),
    .key    (req_key),
    .blk_key(blk_key),
    .exc    (exc),
    .nbytes (nbytes)
  );

  // one storage lane per byte position of the word; lane i holds address%LANES == i
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    int         pos;
    int         bsel;
    logic       sel;
    logic [7:0] wb;
    logic [8:0] rd;

    always_comb begin
      pos  = i - int'(req_addr[LANE_W-1:0]);
      sel  = (pos >= 0) && (pos < int'(nbytes));
      bsel = sel ? (int'(nbytes) - 1 - pos) : 0;
      wb   = 8'(req_wdata >> (8 * bsel));
    end

    mau_lane_ram #(.ROWS(ROWS), .ROW_W(ROW_W), .W(9)) u_ram (
      .clk  (clk),
      .en   (accept && sel && !exc_any),
      .we   (req_write),
      .addr (req_addr[LANE_W +: ROW_W]),
      .wdata({odd_par(wb) ^ req_bad_par, wb}),
      .rdata(rd)
    );

    assign sel_vec[i] = sel;
    assign lane_rd[i] = rd;
    assign par_bad[i] = sel_q[i] && !(^rd);
  end

  assign exc_any_q = exc_q.addr | exc_q.spec | exc_q.prot;
  assign mchk      = !write_q && !exc_any_q && (|par_bad);

  // right-justify the returned bytes over the old destination
  always_comb begin
    merged = dest_q;
    src_ln = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < int'(nbytes_q)) begin
        src_ln = LANE_W'(int'(addr_lo_q) + int'(nbytes_q) - 1 - k);
        merged[8*k +: 8] = lane_rd[src_ln][7:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vq    <= 1'b0;
      exc_q     <= '0;
      write_q   <= 1'b0;
      nbytes_q  <= 3'd1;
      addr_lo_q <= '0;
      sel_q     <= '0;
      dest_q    <= '0;
    end else if (accept) begin
      rsp_vq    <= 1'b1;
      exc_q     <= exc;
      write_q   <= req_write;
      nbytes_q  <= nbytes;
      addr_lo_q <= req_addr[LANE_W-1:0];
      sel_q     <= exc_any ? '0 : sel_vec;
    end else if (rsp_vq && rsp_ready) begin
      rsp_vq <= 1'b0;
      if (!write_q && !exc_any_q && !mchk) dest_q <= merged;
    end
  end

  assign rsp_valid    = rsp_vq;
  assign rsp_addr_exc = rsp_vq && exc_q.addr;
  assign rsp_spec_exc = rsp_vq && exc_q.spec;
  assign rsp_prot_exc = rsp_vq && exc_q.prot;
  assign rsp_mchk     = rsp_vq && mchk;
  assign rsp_data     = (write_q || exc_any_q || mchk) ? dest_q : merged;
  assign dest_o       = dest_q;

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid) else $error("no response after accept"); // R1
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_mchk)
                                   && $stable(rsp_prot_exc))) else $error("response moved"); // R1
  AST_KEY_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && req_key == '0) |=> !rsp_prot_exc) else $error("zero key refused"); // R6
  AST_READ_NO_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write) |=> !rsp_prot_exc) else $error("read drew protection"); // R6
  AST_DEST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && (rsp_addr_exc || rsp_spec_exc || rsp_prot_exc || rsp_mchk))
    |=> $stable(dest_o)) else $error("destination changed on exception"); // R9
  AST_HALF_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !write_q && nbytes_q == 3'd2) |-> rsp_data[DATA_W-1:16] == dest_o[DATA_W-1:16])
    else $error("halfword read touched upper bits"); // R5
  AST_MCHK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_mchk |-> (!rsp_addr_exc && !rsp_spec_exc && !rsp_prot_exc)) else $error("machine check mixed"); // R8

endmodule

// File: tb/sim_byte_access_unit.sv
`timescale 1ns/1ps
module sim_byte_access_unit;

  localparam int MEMB = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [23:0] req_addr = '0;
  logic [3:0]  req_key = '0;
  logic [31:0] req_wdata = '0;
  logic        req_bad_par = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        rsp_addr_exc, rsp_spec_exc, rsp_prot_exc, rsp_mchk;
  logic [31:0] dest_o;
  logic        key_we = 1'b0;
  logic [0:0]  key_blk = '0;
  logic [3:0]  key_val = '0;

  always #2 clk = ~clk;

  byte_access_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_key(req_key),
    .req_wdata(req_wdata), .req_bad_par(req_bad_par),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_addr_exc(rsp_addr_exc), .rsp_spec_exc(rsp_spec_exc),
    .rsp_prot_exc(rsp_prot_exc), .rsp_mchk(rsp_mchk), .dest_o(dest_o),
    .key_we(key_we), .key_blk(key_blk), .key_val(key_val)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit rand_rdy = 0;

  // behavioural reference
  logic [8:0]  mm [int];
  logic [3:0]  mkeys [2];
  logic [31:0] m_dest;
  bit          m_rv, m_wr, m_ae, m_se, m_pe, m_mc;
  logic [31:0] m_data;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rv = 0; m_dest = '0; mkeys[0] = '0; mkeys[1] = '0;
    end else begin
      if (m_rv) begin
        if (rsp_ready) begin
          if (!m_wr && !m_ae && !m_se && !m_pe && !m_mc) m_dest = m_data;
          m_rv = 0;
        end
      end else if (req_valid) begin
        int n;
        int a;
        logic [31:0] nd;
        n = (req_size == 2'd1) ? 2 : (req_size == 2'd2) ? 4 : 1;
        a = int'(req_addr);
        m_wr = req_write;
        m_se = (req_size == 2'd3) || (req_size == 2'd1 && req_addr[0]) ||
               (req_size == 2'd2 && req_addr[1:0] != 2'b00);
        m_ae = (a + n - 1) >= MEMB;
        m_pe = req_write && !m_ae && req_key != 0 && req_key != mkeys[(a / 2048) % 2];
        m_mc = 0;
        m_data = m_dest;
        if (!m_ae && !m_se && !m_pe) begin
          if (req_write) begin
            for (int j = 0; j < n; j++) begin
              logic [7:0] b;
              b = 8'(req_wdata >> (8 * (n - 1 - j)));
              mm[a + j] = {(~^b) ^ req_bad_par, b};
            end
          end else begin
            nd = m_dest;
            for (int j = 0; j < n; j++) begin
              logic [8:0] v;
              v = mm[a + j];
              if (!(^v)) m_mc = 1;
              nd[8 * (n - 1 - j) +: 8] = v[7:0];
            end
            if (!m_mc) m_data = nd;
          end
        end
        m_rv = 1;
      end
      if (key_we) mkeys[key_blk] = key_val;
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 req_ready", {31'd0, req_ready}, {31'd0, !m_rv});
      chk("R1 rsp_valid", {31'd0, rsp_valid}, {31'd0, m_rv});
      chk("R9 dest_o", dest_o, m_dest);
      if (m_rv) begin
        chk("R5 rsp_data", rsp_data, m_data);
        chk("R3 addr_exc", {31'd0, rsp_addr_exc}, {31'd0, m_ae});
        chk("R2 spec_exc", {31'd0, rsp_spec_exc}, {31'd0, m_se});
        chk("R6 prot_exc", {31'd0, rsp_prot_exc}, {31'd0, m_pe});
        chk("R8 mchk", {31'd0, rsp_mchk}, {31'd0, m_mc});
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rand_rdy) rsp_ready = 1'($urandom_range(0, 1));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R1 watchdog expired actual=%0d expected<=100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_req(input bit wr, input logic [1:0] sz, input logic [23:0] a,
                        input logic [3:0] k, input logic [31:0] wd, input bit bad);
    bit r;
    req_valid = 1; req_write = wr; req_size = sz; req_addr = a;
    req_key = k; req_wdata = wd; req_bad_par = bad;
    forever begin
      @(negedge clk); r = req_ready;
      @(posedge clk);
      if (r) break;
    end
    #1 req_valid = 0; req_bad_par = 0;
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic load_key(input logic blk, input logic [3:0] v);
    key_we = 1; key_blk = blk; key_val = v;
    @(posedge clk); #1 key_we = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R10 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R10 dest", dest_o, 32'd0);
    @(posedge clk); #1 rst_n = 1;

    for (int a = 0; a < 64; a += 4) do_req(1, 2, 24'(a), 0, 32'hA5000000 | a, 0);
    for (int a = 'h800; a < 'h840; a += 4) do_req(1, 2, 24'(a), 0, 32'hC0DE0000 | a, 0);
    do_req(1, 2, 24'hFFC, 0, 32'h0BADF00D, 0);

    // R7: block 1 gets key 5
    load_key(1, 4'd5);

    // R4 / R5 ordering and right-justification
    do_req(1, 2, 24'h10, 0, 32'hA1B2C3D4, 0);
    do_req(1, 2, 24'h14, 0, 32'h11223344, 0);
    do_req(0, 2, 24'h10, 3, 0, 0); settle();
    chk("R4 word read", dest_o, 32'hA1B2C3D4);
    do_req(0, 1, 24'h16, 3, 0, 0); settle();
    chk("R5 half keeps upper", dest_o, 32'hA1B23344);
    do_req(0, 0, 24'h14, 0, 0, 0); settle();
    chk("R4 byte at start address", dest_o, 32'hA1B23311);

    // R6 protection in block 1
    do_req(1, 1, 24'h806, 3, 32'h0000BEEF, 0);
    do_req(0, 1, 24'h806, 3, 0, 0); settle();
    chk("R6 refused store left data", dest_o, 32'hA1B20804);
    do_req(1, 1, 24'h806, 5, 32'h0000BEEF, 0);
    do_req(0, 1, 24'h806, 9, 0, 0); settle();
    chk("R6 matching key stored", dest_o, 32'hA1B2BEEF);
    do_req(1, 1, 24'h806, 0, 32'h00001234, 0);
    do_req(0, 1, 24'h806, 0, 0, 0); settle();
    chk("R6 zero key stored", dest_o, 32'hA1B21234);

    // R2 specification cases
    do_req(0, 1, 24'h11, 0, 0, 0); settle();
    chk("R2 odd halfword", dest_o, 32'hA1B21234);
    do_req(0, 2, 24'h12, 0, 0, 0);
    do_req(1, 3, 24'h20, 0, 32'hFFFFFFFF, 0);
    do_req(1, 2, 24'h22, 0, 32'hFFFFFFFF, 0);

    // R3 addressing limit
    do_req(0, 2, 24'hFFC, 0, 0, 0); settle();
    chk("R3 last word in range", dest_o, 32'h0BADF00D);
    do_req(0, 0, 24'h1000, 0, 0, 0);
    do_req(0, 2, 24'hFFFFFC, 0, 0, 0);
    do_req(1, 1, 24'hFFFFFE, 0, 32'h5555, 0); settle();
    chk("R3 dest unchanged", dest_o, 32'h0BADF00D);

    // R8 parity
    do_req(1, 0, 24'h21, 0, 32'h0000007E, 1);
    do_req(0, 0, 24'h21, 0, 0, 0); settle();
    chk("R8 bad byte held dest", dest_o, 32'h0BADF00D);
    do_req(0, 2, 24'h20, 0, 0, 0); settle();
    chk("R9 word with bad byte", dest_o, 32'h0BADF00D);
    do_req(1, 0, 24'h21, 0, 32'h0000007E, 0);
    do_req(0, 0, 24'h21, 0, 0, 0); settle();
    chk("R8 good parity read", dest_o, 32'h0BADF07E);

    // R7 key change in block 0
    load_key(0, 4'd7);
    do_req(1, 2, 24'h30, 2, 32'h01020304, 0);
    do_req(1, 2, 24'h34, 7, 32'h05060708, 0);
    do_req(0, 2, 24'h34, 2, 0, 0); settle();
    chk("R7 new key admitted", dest_o, 32'h05060708);
    load_key(0, 4'd0);

    // R1 back-pressure
    rsp_ready = 0;
    do_req(0, 2, 24'h10, 0, 0, 0);
    fork
      do_req(0, 0, 24'h12, 0, 0, 0);
      begin repeat (4) @(posedge clk); #1 rsp_ready = 1; end
    join
    settle();
    chk("R1 queued request served", dest_o, 32'hA1B2C3C3);

    // mixed traffic
    rand_rdy = 1;
    for (int i = 0; i < 400; i++) begin
      int r;
      logic [23:0] a;
      r = $urandom_range(0, 9);
      if (r < 4)       a = 24'($urandom_range(0, 63));
      else if (r < 8)  a = 24'('h800 + $urandom_range(0, 63));
      else if (r == 8) a = 24'('hFFC + $urandom_range(0, 8));
      else             a = 24'($urandom);
      if ($urandom_range(0, 15) == 0) load_key(1'($urandom_range(0, 1)), 4'($urandom_range(0, 3)));
      do_req(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), a,
             4'($urandom_range(0, 3)), $urandom, ($urandom_range(0, 7) == 0));
    end
    rand_rdy = 0;
    #1 rsp_ready = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule